// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This block carries out exactly one AES round on a 128-bit state for each operation it accepts. A caller supplies a state, a round key and a 3-bit operation code. The block returns one 128-bit result per accepted operation. Five operations are offered:

- a full forward round;
- a closing forward round;
- a full inverse round, in the equivalent-inverse-cipher arrangement;
- a closing inverse round;
- a key-conditioning step that applies inverse MixColumns to its data input.

The caller owns the rest of the work. It applies the initial key whitening, steps through the rounds and expands the keys. The key-conditioning step converts forward round keys into the keys the inverse rounds need. With these pieces, AES-128, AES-192 and AES-256 encryption and decryption can all be built from single-round steps.

Control is a two-state machine. `ST_IDLE` means no result is held. `ST_HOLD` means a result is presented on `out_data`. The machine has four transitions:

- `T_ACCEPT` moves from `ST_IDLE` to `ST_HOLD` when an operation is accepted.
- `T_DRAIN` moves from `ST_HOLD` to `ST_IDLE` when the result is taken and no new operation arrives.
- `T_CHAIN` stays in `ST_HOLD` when the result is taken and a new operation is accepted in the same cycle.
- `T_STALL` stays in `ST_HOLD` while the result is not taken.

Bytes are numbered column-major. Byte i of a 128-bit word sits in bits [8i+7:8i], its row is i mod 4 and its column is i div 4.

Top module: `aes_round_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `in_ready` is 1 and `out_data` is all zeros.
- R2: Op code 0 (full forward round) returns MixColumns(ShiftRows(SubBytes(state))) XOR key. ShiftRows moves row r left by r columns. MixColumns uses the circulant coefficients {2,3,1,1} over GF(2^8) modulo 0x11B.
- R3: Op code 1 (closing forward round) returns ShiftRows(SubBytes(state)) XOR key. A state made of one repeated byte v with a zero key returns the forward S-box of v in every byte.
- R4: Op code 2 (full inverse round) returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. InvShiftRows moves row r right by r columns. InvMixColumns uses the coefficients {14,11,13,9}.
- R5: Op code 3 (closing inverse round) returns InvSubBytes(InvShiftRows(state)) XOR key. A repeated byte v with a zero key returns the inverse S-box of v in every byte.
- R6: Op code 4 (key conditioning) returns InvMixColumns of `in_state`. The value on `in_key` has no effect on the result.
- R7: Op codes 5, 6 and 7 return `in_state` unchanged. The value on `in_key` has no effect on the result.
- R8: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 and `out_data` holds that operation's result from that edge onward.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_data` keep their values.
- R10: While `out_valid` and `out_ready` are both 1, `in_ready` is 1. A new operation can then be accepted in the same cycle the result is taken, with no idle cycle between them.
- R11: Chains of these operations reproduce the published AES-128, AES-192 and AES-256 encryption test vectors. With keys conditioned by op code 4, they also decrypt those vectors back to the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (0..4 defined, 5..7 pass-through) |
| in_state | input | 128 | State or key to transform |
| in_key | input | 128 | Round key to add |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result of the last accepted operation |

## Verification
A corrupted S-box entry, a wrong multiplier coefficient or a misplaced row rotation shows up on `out_data` one edge after the offending operation is accepted. These faults are exposed quickly because the bench sweeps all 256 byte values through both S-box directions and runs every operation code on many random states. A state machine stuck in the wrong state shows on `in_ready` or `out_valid` in the same or next cycle, which the backpressure and chaining sequences observe directly. A subtle datapath error that slips past single rounds is compounded over 10 to 14 chained rounds, so the full-cipher test vectors fail on it.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;
    localparam int NROWS  = 4;
    localparam int NCOLS  = 4;
    localparam int NBYTES = NROWS * NCOLS;
    localparam int BLK_W  = NBYTES * 8;
    localparam int OP_W   = 3;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [OP_W-1:0] {
        OP_ENC      = 3'd0,
        OP_ENC_LAST = 3'd1,
        OP_DEC      = 3'd2,
        OP_DEC_LAST = 3'd3,
        OP_IMC      = 3'd4
    } op_e;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] t;
        acc = 8'h00;
        t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_x2(t);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] sub_fwd(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sub_inv(input logic [7:0] a);
        return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

    // row r taken from column (c + r) for forward, (c - r) for inverse
    function automatic blk_t row_shift(input blk_t s, input logic inverse);
        blk_t o;
        int   src;
        o = '0;
        for (int c = 0; c < NCOLS; c++) begin
            for (int r = 0; r < NROWS; r++) begin
                src = inverse ? ((c - r + NCOLS) % NCOLS) : ((c + r) % NCOLS);
                o[8*(c*NROWS+r) +: 8] = s[8*(src*NROWS+r) +: 8];
            end
        end
        return o;
    endfunction
endpackage

// File: rtl/aes_byte_sub.sv
module aes_byte_sub
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  blk_t din,
    output blk_t dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        if (INVERSE) begin : g_inv
            assign dout[8*i +: 8] = sub_inv(din[8*i +: 8]);
        end else begin : g_fwd
            assign dout[8*i +: 8] = sub_fwd(din[8*i +: 8]);
        end
    end
endmodule

// File: rtl/aes_mix_cols.sv
module aes_mix_cols
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  blk_t din,
    output blk_t dout
);
    localparam logic [31:0] COEF_FWD = {8'h01, 8'h01, 8'h03, 8'h02};
    localparam logic [31:0] COEF_INV = {8'h09, 8'h0d, 8'h0b, 8'h0e};
    localparam logic [31:0] COEF     = INVERSE ? COEF_INV : COEF_FWD;

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            logic [7:0] acc;
            always_comb begin
                acc = 8'h00;
                for (int j = 0; j < NROWS; j++) begin
                    acc = acc ^ gf_mul(din[8*(c*NROWS+j) +: 8],
                                       COEF[8*((j - r + NROWS) % NROWS) +: 8]);
                end
            end
            assign dout[8*(c*NROWS+r) +: 8] = acc;
        end
    end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
    import aes_rnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [BLK_W-1:0]  in_state,
    input  logic [BLK_W-1:0]  in_key,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BLK_W-1:0]  out_data
);
    typedef enum logic {ST_IDLE, ST_HOLD} fsm_e;

    fsm_e cur_st;
    fsm_e nxt_st;
    logic accept;
    op_e  op_sel;

    blk_t fwd_sub, fwd_shift, fwd_mix;
    blk_t inv_shift, inv_sub, imix_in, imix_out;
    blk_t result_d;

    // ---------------- control ----------------
    always_comb begin
        unique case (cur_st)
            ST_IDLE: in_ready = 1'b1;
            ST_HOLD: in_ready = out_ready;
        endcase
    end

    assign accept    = in_valid && in_ready;
    assign out_valid = (cur_st == ST_HOLD);

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE: if (accept) nxt_st = ST_HOLD;                 // T_ACCEPT
            ST_HOLD: if (out_ready) nxt_st = accept ? ST_HOLD      // T_CHAIN
                                                    : ST_IDLE;     // T_DRAIN
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= ST_IDLE;
        else        cur_st <= nxt_st;
    end

    // ---------------- datapath ----------------
    aes_byte_sub #(.INVERSE(1'b0)) u_sub_fwd (.din(in_state), .dout(fwd_sub));
    assign fwd_shift = row_shift(fwd_sub, 1'b0);
    aes_mix_cols #(.INVERSE(1'b0)) u_mix_fwd (.din(fwd_shift), .dout(fwd_mix));

    assign inv_shift = row_shift(in_state, 1'b1);
    aes_byte_sub #(.INVERSE(1'b1)) u_sub_inv (.din(inv_shift), .dout(inv_sub));

    assign op_sel  = op_e'(in_op);
    // one inverse mixer shared by the inverse round and key conditioning
    assign imix_in = (op_sel == OP_IMC) ? in_state : inv_sub;
    aes_mix_cols #(.INVERSE(1'b1)) u_mix_inv (.din(imix_in), .dout(imix_out));

    always_comb begin
        case (op_sel)
            OP_ENC:      result_d = fwd_mix   ^ in_key;
            OP_ENC_LAST: result_d = fwd_shift ^ in_key;
            OP_DEC:      result_d = imix_out  ^ in_key;
            OP_DEC_LAST: result_d = inv_sub   ^ in_key;
            OP_IMC:      result_d = imix_out;
            default:     result_d = in_state;
        endcase
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (accept) out_data <= result_d;
    end
endmodule

// File: rtl/aes_round_unit_chk.sv
module aes_round_unit_chk
    import aes_rnd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [BLK_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && in_ready);

    p_result_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_block_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    p_chain_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> in_ready);

    p_drop_only_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(in_valid && in_ready) && out_ready) |=> !out_valid);
endmodule

bind aes_round_unit aes_round_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_aes_round_unit.sv
`timescale 1ns/1ps
module sim_aes_round_unit;
    localparam real HALF_NS  = 2.5;
    localparam int  WD_CYC   = 200000;
    localparam int  N_RAND   = 150;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [127:0] in_state = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]   sb  [256];
    logic [7:0]   isb [256];
    logic [127:0] rk  [15];

    always #(HALF_NS) clk = ~clk;

    aes_round_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_state(in_state), .in_key(in_key),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    initial begin
        #(2.0 * HALF_NS * WD_CYC);
        n_tests++; n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------------- independent reference model ----------------
    function automatic logic [7:0] m_xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) r ^= x;
            x = m_xt(x);
            y = y >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_rl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic build_tables();
        logic [7:0] p = 1;
        logic [7:0] q = 1;
        do begin
            p = p ^ m_xt(p);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ m_rl(q, 1) ^ m_rl(q, 2) ^ m_rl(q, 3) ^ m_rl(q, 4) ^ 8'h63;
        end while (p != 1);
        sb[0] = 8'h63;
        for (int i = 0; i < 256; i++) isb[sb[i]] = i[7:0];
    endtask

    function automatic logic [127:0] m_mix(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = s[32*c +: 8]; a1 = s[32*c+8 +: 8]; a2 = s[32*c+16 +: 8]; a3 = s[32*c+24 +: 8];
            if (!inv) begin
                o[32*c    +: 8] = m_mul(a0,2) ^ m_mul(a1,3) ^ a2 ^ a3;
                o[32*c+8  +: 8] = a0 ^ m_mul(a1,2) ^ m_mul(a2,3) ^ a3;
                o[32*c+16 +: 8] = a0 ^ a1 ^ m_mul(a2,2) ^ m_mul(a3,3);
                o[32*c+24 +: 8] = m_mul(a0,3) ^ a1 ^ a2 ^ m_mul(a3,2);
            end else begin
                o[32*c    +: 8] = m_mul(a0,14) ^ m_mul(a1,11) ^ m_mul(a2,13) ^ m_mul(a3,9);
                o[32*c+8  +: 8] = m_mul(a0,9)  ^ m_mul(a1,14) ^ m_mul(a2,11) ^ m_mul(a3,13);
                o[32*c+16 +: 8] = m_mul(a0,13) ^ m_mul(a1,9)  ^ m_mul(a2,14) ^ m_mul(a3,11);
                o[32*c+24 +: 8] = m_mul(a0,11) ^ m_mul(a1,13) ^ m_mul(a2,9)  ^ m_mul(a3,14);
            end
        end
        return o;
    endfunction

    // forward: sub then shift left; inverse: shift right then inverse sub
    function automatic logic [127:0] m_subshift(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                if (!inv) o[8*(4*c+r) +: 8] = sb[s[8*(4*((c+r)&3)+r) +: 8]];
                else      o[8*(4*c+r) +: 8] = isb[s[8*(4*((c+4-r)&3)+r) +: 8]];
        return o;
    endfunction

    function automatic logic [127:0] m_round(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k);
        case (op)
            3'd0: return m_mix(m_subshift(s, 0), 0) ^ k;
            3'd1: return m_subshift(s, 0) ^ k;
            3'd2: return m_mix(m_subshift(s, 1), 1) ^ k;
            3'd3: return m_subshift(s, 1) ^ k;
            3'd4: return m_mix(s, 1);
            default: return s;
        endcase
    endfunction

    function automatic logic [127:0] le128(input logic [127:0] v);
        logic [127:0] o;
        for (int i = 0; i < 16; i++) o[8*i +: 8] = v[127-8*i -: 8];
        return o;
    endfunction

    function automatic logic [31:0] sub_word(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    task automatic expand(input logic [255:0] kv, input int nk);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        int nr = nk + 6;
        for (int i = 0; i < nk; i++)
            for (int j = 0; j < 4; j++)
                w[i][8*j +: 8] = kv[32*nk - 1 - 8*(4*i+j) -: 8];
        for (int i = nk; i < 4*(nr+1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = sub_word({t[7:0], t[31:8]}) ^ {24'h0, rc};
                rc = m_xt(rc);
            end else if (nk > 6 && i % nk == 4) begin
                t = sub_word(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r <= nr; r++) rk[r] = {w[4*r+3], w[4*r+2], w[4*r+1], w[4*r]};
    endtask

    // ---------------- drivers ----------------
    task automatic rand128(output logic [127:0] v);
        v = {$urandom(), $urandom(), $urandom(), $urandom()};
    endtask

    task automatic run_op(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k,
                          output logic [127:0] res);
        @(negedge clk);
        in_op = op; in_state = s; in_key = k; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R8 out_valid after accept", {127'h0, out_valid}, 128'h1);
        res = out_data;
        @(posedge clk); #1;
    endtask

    task automatic cipher_vec(input logic [255:0] kv, input int nk, input logic [127:0] ct_be);
        logic [127:0] pt = le128(128'h00112233445566778899aabbccddeeff);
        logic [127:0] ct = le128(ct_be);
        logic [127:0] s;
        logic [127:0] dk;
        int nr = nk + 6;
        expand(kv, nk);
        s = pt ^ rk[0];
        for (int r = 1; r < nr; r++) run_op(3'd0, s, rk[r], s);
        run_op(3'd1, s, rk[nr], s);
        chk(s === ct, $sformatf("R11 encrypt nk=%0d", nk), s, ct);
        s = ct ^ rk[nr];
        for (int r = nr - 1; r >= 1; r--) begin
            run_op(3'd4, rk[r], $urandom(), dk);
            run_op(3'd2, s, dk, s);
        end
        run_op(3'd3, s, rk[0], s);
        chk(s === pt, $sformatf("R11 decrypt nk=%0d", nk), s, pt);
    endtask

    initial begin
        logic [127:0] s, k, k2, r1, r2, exp_a, exp_b;
        build_tables();

        // R1: reset
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 handshake in reset",
            {126'h0, out_valid, in_ready}, 128'h1);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 handshake after reset",
            {126'h0, out_valid, in_ready}, 128'h1);
        chk(out_data === '0, "R1 out_data after reset", out_data, 128'h0);

        // R3 / R5: exhaustive S-box sweeps
        for (int v = 0; v < 256; v++) begin
            run_op(3'd1, {16{v[7:0]}}, '0, r1);
            chk(r1 === {16{sb[v]}}, $sformatf("R3 sbox v=%0d", v), r1, {16{sb[v]}});
            run_op(3'd3, {16{v[7:0]}}, '0, r1);
            chk(r1 === {16{isb[v]}}, $sformatf("R5 inv sbox v=%0d", v), r1, {16{isb[v]}});
        end

        // R2..R5 random states
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < N_RAND; n++) begin
                rand128(s); rand128(k);
                run_op(op[2:0], s, k, r1);
                exp_a = m_round(op[2:0], s, k);
                chk(r1 === exp_a, $sformatf("R%0s op=%0d", op == 0 ? "2" : op == 1 ? "3" : op == 2 ? "4" : "5", op), r1, exp_a);
            end
        end
        // named tags for traceability: R2 R4 covered above by op 0 and op 2

        // R6: key conditioning ignores key
        for (int n = 0; n < N_RAND; n++) begin
            rand128(s); rand128(k); rand128(k2);
            run_op(3'd4, s, k, r1);
            run_op(3'd4, s, k2, r2);
            exp_a = m_mix(s, 1);
            chk(r1 === exp_a && r2 === exp_a, "R6 inverse mix, key ignored", r2, exp_a);
        end

        // R7: unused codes pass the state through
        for (int op = 5; op < 8; op++) begin
            rand128(s); rand128(k);
            run_op(op[2:0], s, k, r1);
            chk(r1 === s, $sformatf("R7 pass-through op=%0d", op), r1, s);
        end

        // R9 / R10: backpressure then chained accept
        rand128(s); rand128(k); exp_a = m_round(3'd0, s, k);
        rand128(k2); exp_b = m_round(3'd2, k2, k);
        @(negedge clk);
        in_op = 3'd0; in_state = s; in_key = k; in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk); #1;
        in_op = 3'd2; in_state = k2;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(in_ready === 1'b0, "R9 in_ready low while held", {127'h0, in_ready}, 128'h0);
            chk(out_valid === 1'b1 && out_data === exp_a, "R9 result held", out_data, exp_a);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready === 1'b1, "R10 ready when result taken", {127'h0, in_ready}, 128'h1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === exp_b, "R10 chained result", out_data, exp_b);
        @(posedge clk); #1;
        chk(out_valid === 1'b0, "R8 drains after take", {127'h0, out_valid}, 128'h0);
        out_ready = 1'b0;

        // R11: full cipher chains for all key sizes
        cipher_vec(256'h000102030405060708090a0b0c0d0e0f, 4,
                   128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        cipher_vec(256'h000102030405060708090a0b0c0d0e0f1011121314151617, 6,
                   128'hdda97ca4864cdfe06eaf70a0ec0d7191);
        cipher_vec(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 8,
                   128'h8ea2b7ca516745bfeafc49904b496089);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule